// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a 30-bit physical address by reading two tables in memory, one after the other. The top 12 bits of the virtual address select an entry in an outer table. That table starts at the address held in a root register. The outer entry supplies the base of an inner table. The next 8 bits of the virtual address select an entry in that inner table, and the inner entry supplies an 18-bit physical page number. The low 12 bits of the virtual address pass through unchanged as the page offset.

A client presents one virtual address at a time on a valid/ready request channel. The walker then issues the outer read and waits for its data. Only after that does it issue the inner read, because the inner address depends on the outer data. The result is held on a response channel until the client takes it. Memory is reached through a read port with a request handshake and a response strobe. The port may take any number of cycles to answer, and only one read is outstanding at a time. Each table entry has a valid flag. A missing entry at either level ends the walk early with a fault that names the level.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: The first memory read of a walk goes to root + 4 × outer index, computed modulo 2^30. The outer index is virtual address bits [31:20].
- R3: The second read goes to T + 4 × inner index, modulo 2^30. T is bits [29:0] of the outer entry and the inner index is virtual address bits [19:12]. This read is issued only after the outer data has returned with bit 31 (valid) set.
- R4: When both entries are valid, `rsp_paddr` is {inner entry bits [17:0], virtual address bits [11:0]} and `rsp_fault` is 0.
- R5: An outer entry with bit 31 clear ends the walk after exactly one memory read. The response has `rsp_fault` = 1, `rsp_fault_level` = 0 and `rsp_paddr` = 0.
- R6: An inner entry with bit 31 clear gives `rsp_fault` = 1, `rsp_fault_level` = 1 and `rsp_paddr` = 0, after exactly two memory reads.
- R7: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. The walker then waits any number of cycles for `mem_rsp_valid`. It never asserts `mem_req_valid` while a read is outstanding.
- R8: A root write takes effect only in a cycle where the walker is idle and no request is presented. A write during a walk, or in the same cycle as a request, is ignored.
- R9: `req_ready` is 0 from the acceptance of a request until its response is taken. `rsp_valid`, `rsp_paddr`, `rsp_fault` and `rsp_fault_level` hold steady until `rsp_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_wr_en | input | 1 | Write strobe for the root pointer |
| root_wr_addr | input | 30 | New root pointer value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Client takes the result |
| rsp_paddr | output | 30 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Walk hit an invalid entry |
| rsp_fault_level | output | 1 | 0 = outer entry invalid, 1 = inner entry invalid |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 30 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Table entry, bit 31 = valid |

## Verification
The bench goes after the dependency between the two reads. A walker that computed the inner address from a stale or wrong base, or that issued the inner read before the outer data arrived, would log an inner read address that differs from the bench's arithmetic. Walks whose outer entry is invalid must show exactly one read, so a design that issued the inner read anyway is caught by the read count. The bench also writes the root during a walk and in the same cycle as a request. A walker that took those writes would send the next walk's outer read to the wrong address. Random accept delays, response latencies up to 13 cycles, a root near the top of the address space (so the entry address wraps) and a stalled response channel catch designs that drop a held request, lose a late response or change the result before it is taken.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      WS_IDLE     = 3'd0,
      WS_OUT_REQ  = 3'd1,
      WS_OUT_WAIT = 3'd2,
      WS_IN_REQ   = 3'd3,
      WS_IN_WAIT  = 3'd4,
      WS_DONE     = 3'd5
   } walk_state_e;

   localparam logic LVL_OUTER = 1'b0;
   localparam logic LVL_INNER = 1'b1;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
   parameter int AW       = 30,
   parameter int IDX_W    = 12,
   parameter int ENTRY_LG2 = 2
) (
   input  logic [AW-1:0]    base,
   input  logic [IDX_W-1:0] idx,
   output logic [AW-1:0]    entry_addr
);

   localparam int PAD_W = AW - IDX_W - ENTRY_LG2;

   if (PAD_W < 1) begin : g_bad_width
      $error("ptw_entry_addr: index plus entry size must be narrower than the address");
   end

   logic [AW-1:0] offset_bytes;

   if (ENTRY_LG2 == 0) begin : g_byte_entries
      assign offset_bytes = {{PAD_W{1'b0}}, idx};
   end else begin : g_wide_entries
      assign offset_bytes = {{PAD_W{1'b0}}, idx, {ENTRY_LG2{1'b0}}};
   end

   assign entry_addr = base + offset_bytes;

endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
   parameter int DATA_W    = 32,
   parameter int VALID_BIT = 31,
   parameter int FIELD_W   = 30
) (
   input  logic [DATA_W-1:0]  entry,
   output logic               ent_valid,
   output logic [FIELD_W-1:0] ent_field
);

   if (VALID_BIT >= DATA_W) begin : g_bad_valid
      $error("ptw_entry_decode: valid flag lies outside the entry");
   end
   if (FIELD_W > VALID_BIT) begin : g_bad_field
      $error("ptw_entry_decode: payload overlaps the valid flag");
   end

   assign ent_valid = entry[VALID_BIT];
   assign ent_field = entry[FIELD_W-1:0];

   logic unused_entry_bits;
   assign unused_entry_bits = ^entry;

endmodule

// File: rtl/ptw_root_reg.sv
module ptw_root_reg #(
   parameter int            AW        = 30,
   parameter logic [AW-1:0] RESET_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic          may_write,
   output logic [AW-1:0] root
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         root <= RESET_VAL;
      end else if (wr_en && may_write) begin
         root <= wr_addr;
      end
   end

   // R8
   root_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !may_write |=> $stable(root));

endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
   import ptw_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int OUTER_W   = 12,
   parameter int INNER_W   = 8,
   parameter int OFF_W     = 12,
   parameter int AW        = 30,
   parameter int DATA_W    = 32,
   parameter int PPN_W     = 18,
   parameter int VALID_BIT = 31,
   parameter int ENTRY_LG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     root,
   output logic              root_may_write,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [AW-1:0]     rsp_paddr,
   output logic              rsp_fault,
   output logic              rsp_fault_level,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [AW-1:0]     mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data
);

   localparam int OUTER_LSB = INNER_W + OFF_W;

   if (OUTER_W + INNER_W + OFF_W != VA_W) begin : g_bad_split
      $error("ptw_walk_ctrl: index and offset widths must fill the virtual address");
   end
   if (PPN_W + OFF_W != AW) begin : g_bad_pa
      $error("ptw_walk_ctrl: page number plus offset must equal the physical width");
   end

   walk_state_e           state_q, state_d;
   logic [VA_W-1:0]       vaddr_q;
   logic [AW-1:0]         table_q;
   logic [AW-1:0]         paddr_q;
   logic                  fault_q;
   logic                  level_q;

   logic [OUTER_W-1:0]    outer_idx;
   logic [INNER_W-1:0]    inner_idx;
   logic [OFF_W-1:0]      page_off;

   logic                  tbl_valid;
   logic [AW-1:0]         tbl_base;
   logic                  page_valid;
   logic [PPN_W-1:0]      page_num;

   logic [AW-1:0]         outer_addr;
   logic [AW-1:0]         inner_addr;

   logic                  accept;
   logic                  outer_back;
   logic                  inner_back;

   assign outer_idx = vaddr_q[OUTER_LSB +: OUTER_W];
   assign inner_idx = vaddr_q[OFF_W +: INNER_W];
   assign page_off  = vaddr_q[OFF_W-1:0];

   ptw_entry_decode #(
      .DATA_W   (DATA_W),
      .VALID_BIT(VALID_BIT),
      .FIELD_W  (AW)
   ) u_outer_dec (
      .entry    (mem_rsp_data),
      .ent_valid(tbl_valid),
      .ent_field(tbl_base)
   );

   ptw_entry_decode #(
      .DATA_W   (DATA_W),
      .VALID_BIT(VALID_BIT),
      .FIELD_W  (PPN_W)
   ) u_inner_dec (
      .entry    (mem_rsp_data),
      .ent_valid(page_valid),
      .ent_field(page_num)
   );

   ptw_entry_addr #(
      .AW       (AW),
      .IDX_W    (OUTER_W),
      .ENTRY_LG2(ENTRY_LG2)
   ) u_outer_addr (
      .base      (root),
      .idx       (outer_idx),
      .entry_addr(outer_addr)
   );

   ptw_entry_addr #(
      .AW       (AW),
      .IDX_W    (INNER_W),
      .ENTRY_LG2(ENTRY_LG2)
   ) u_inner_addr (
      .base      (table_q),
      .idx       (inner_idx),
      .entry_addr(inner_addr)
   );

   assign accept     = (state_q == WS_IDLE) && req_valid;
   assign outer_back = (state_q == WS_OUT_WAIT) && mem_rsp_valid;
   assign inner_back = (state_q == WS_IN_WAIT) && mem_rsp_valid;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         WS_IDLE:     if (req_valid) state_d = WS_OUT_REQ;
         WS_OUT_REQ:  if (mem_req_ready) state_d = WS_OUT_WAIT;
         WS_OUT_WAIT: if (mem_rsp_valid) state_d = tbl_valid ? WS_IN_REQ : WS_DONE;
         WS_IN_REQ:   if (mem_req_ready) state_d = WS_IN_WAIT;
         WS_IN_WAIT:  if (mem_rsp_valid) state_d = WS_DONE;
         WS_DONE:     if (rsp_ready) state_d = WS_IDLE;
         default:     state_d = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WS_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vaddr_q <= '0;
         table_q <= '0;
      end else begin
         if (accept) vaddr_q <= req_vaddr;
         if (outer_back && tbl_valid) table_q <= tbl_base;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         paddr_q <= '0;
         fault_q <= 1'b0;
         level_q <= LVL_OUTER;
      end else if (outer_back && !tbl_valid) begin
         paddr_q <= '0;
         fault_q <= 1'b1;
         level_q <= LVL_OUTER;
      end else if (inner_back) begin
         level_q <= LVL_INNER;
         if (page_valid) begin
            paddr_q <= {page_num, page_off};
            fault_q <= 1'b0;
         end else begin
            paddr_q <= '0;
            fault_q <= 1'b1;
         end
      end
   end

   assign req_ready       = (state_q == WS_IDLE);
   assign root_may_write  = (state_q == WS_IDLE) && !req_valid;
   assign mem_req_valid   = (state_q == WS_OUT_REQ) || (state_q == WS_IN_REQ);
   assign mem_req_addr    = (state_q == WS_IN_REQ) ? inner_addr : outer_addr;
   assign rsp_valid       = (state_q == WS_DONE);
   assign rsp_paddr       = paddr_q;
   assign rsp_fault       = fault_q;
   assign rsp_fault_level = level_q;

   // R7
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R7
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

   // R5
   outer_fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (outer_back && !tbl_valid) |=> (!mem_req_valid && rsp_valid && rsp_fault && !rsp_fault_level));

   // R9
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
                                     && $stable(rsp_fault_level)));

   // R9
   busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!rsp_valid && !mem_req_valid));

   // R6
   fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
   parameter int            VA_W      = 32,
   parameter int            OUTER_W   = 12,
   parameter int            INNER_W   = 8,
   parameter int            OFF_W     = 12,
   parameter int            AW        = 30,
   parameter int            DATA_W    = 32,
   parameter int            PPN_W     = 18,
   parameter int            VALID_BIT = 31,
   parameter int            ENTRY_LG2 = 2,
   parameter logic [AW-1:0] ROOT_INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              root_wr_en,
   input  logic [AW-1:0]     root_wr_addr,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [AW-1:0]     rsp_paddr,
   output logic              rsp_fault,
   output logic              rsp_fault_level,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [AW-1:0]     mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data
);

   logic [AW-1:0] root;
   logic          root_may_write;

   ptw_root_reg #(
      .AW       (AW),
      .RESET_VAL(ROOT_INIT)
   ) u_root (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (root_wr_en),
      .wr_addr  (root_wr_addr),
      .may_write(root_may_write),
      .root     (root)
   );

   ptw_walk_ctrl #(
      .VA_W     (VA_W),
      .OUTER_W  (OUTER_W),
      .INNER_W  (INNER_W),
      .OFF_W    (OFF_W),
      .AW       (AW),
      .DATA_W   (DATA_W),
      .PPN_W    (PPN_W),
      .VALID_BIT(VALID_BIT),
      .ENTRY_LG2(ENTRY_LG2)
   ) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .root           (root),
      .root_may_write (root_may_write),
      .req_valid      (req_valid),
      .req_ready      (req_ready),
      .req_vaddr      (req_vaddr),
      .rsp_valid      (rsp_valid),
      .rsp_ready      (rsp_ready),
      .rsp_paddr      (rsp_paddr),
      .rsp_fault      (rsp_fault),
      .rsp_fault_level(rsp_fault_level),
      .mem_req_valid  (mem_req_valid),
      .mem_req_ready  (mem_req_ready),
      .mem_req_addr   (mem_req_addr),
      .mem_rsp_valid  (mem_rsp_valid),
      .mem_rsp_data   (mem_rsp_data)
   );

endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        root_wr_en = 1'b0;
   logic [29:0] root_wr_addr = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [29:0] rsp_paddr;
   logic        rsp_fault;
   logic        rsp_fault_level;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [29:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [29:0] root_cur = '0;
   logic [29:0] read_log [4];
   int          nreads = 0;
   bit          long_lat = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #(CLK_PERIOD/2) clk = ~clk;

   pt_walker dut (
      .clk(clk), .rst_n(rst_n),
      .root_wr_en(root_wr_en), .root_wr_addr(root_wr_addr),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data)
   );

   // Memory content as a pure function of the byte address; bit 31 is the valid flag.
   function automatic logic [31:0] memf(input logic [29:0] a);
      logic [31:0] m;
      m = ({2'b00, a} * 32'h9E37_79B1) ^ ({2'b00, a} >> 5);
      return {(a[6:2] != 5'd7), 1'b0, m[29:0]};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Memory model: random accept, latency 0..3 or 13, one read at a time.
   initial begin
      bit busy = 0;
      int cnt = 0;
      logic [29:0] addr_l = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         mem_req_ready = 1'b0;
         if (busy) begin
            if (mem_req_valid) chk(1'b0, "R7 request while read outstanding", 32'd1, 32'd0);
            if (cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = memf(addr_l);
               busy = 0;
            end else begin
               cnt--;
            end
         end else if (mem_req_valid && lfsr[0]) begin
            mem_req_ready = 1'b1;
            busy   = 1;
            addr_l = mem_req_addr;
            cnt    = long_lat ? 13 : int'(lfsr[3:2]);
            if (nreads < 4) read_log[nreads] = mem_req_addr;
            nreads++;
         end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end
   end

   task automatic set_root(input logic [29:0] r);
      @(negedge clk);
      root_wr_en = 1'b1;
      root_wr_addr = r;
      @(negedge clk);
      root_wr_en = 1'b0;
      root_cur = r;
   endtask

   // poke: 0 none, 1 root write mid-walk, 2 root write with the request
   task automatic walk(input logic [31:0] va, input int hold, input int poke);
      logic [31:0] e1, e2;
      logic [29:0] oa, ia, exp_pa, pa_seen;
      logic        exp_fault, exp_lvl;
      int          exp_reads, waited;
      oa = root_cur + {16'd0, va[31:20], 2'b00};
      e1 = memf(oa);
      ia = '0;
      if (!e1[31]) begin
         exp_fault = 1; exp_lvl = 0; exp_pa = '0; exp_reads = 1;
      end else begin
         ia = e1[29:0] + {20'd0, va[19:12], 2'b00};
         e2 = memf(ia);
         exp_reads = 2; exp_lvl = 1;
         if (!e2[31]) begin exp_fault = 1; exp_pa = '0; end
         else begin exp_fault = 0; exp_pa = {e2[17:0], va[11:0]}; end
      end
      @(negedge clk);
      nreads = 0;
      chk(req_ready === 1'b1, "R9 ready before request", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1;
      req_vaddr = va;
      if (poke == 2) begin root_wr_en = 1'b1; root_wr_addr = ~root_cur; end
      @(negedge clk);
      req_valid = 1'b0;
      root_wr_en = 1'b0;
      waited = 0;
      while (rsp_valid !== 1'b1 && waited < 100) begin
         chk(req_ready === 1'b0, "R9 busy during walk", {31'd0, req_ready}, 32'd0);
         if (poke == 1 && waited == 1) begin root_wr_en = 1'b1; root_wr_addr = root_cur ^ 30'h0155_5000; end
         else root_wr_en = 1'b0;
         @(negedge clk);
         waited++;
      end
      root_wr_en = 1'b0;
      chk(rsp_valid === 1'b1, "R7 response arrives", {31'd0, rsp_valid}, 32'd1);
      pa_seen = rsp_paddr;
      for (int k = 0; k < hold; k++) begin
         @(negedge clk);
         chk(rsp_valid === 1'b1 && rsp_paddr === pa_seen, "R9 response held", {2'b0, rsp_paddr}, {2'b0, pa_seen});
      end
      chk(rsp_fault === exp_fault, exp_fault ? (exp_lvl ? "R6 fault flag" : "R5 fault flag") : "R4 no fault",
          {31'd0, rsp_fault}, {31'd0, exp_fault});
      if (exp_fault) chk(rsp_fault_level === exp_lvl, exp_lvl ? "R6 level" : "R5 level",
                         {31'd0, rsp_fault_level}, {31'd0, exp_lvl});
      chk(rsp_paddr === exp_pa, exp_fault ? "R5 R6 zero address on fault" : "R4 physical address",
          {2'b0, rsp_paddr}, {2'b0, exp_pa});
      chk(nreads == exp_reads, exp_reads == 1 ? "R5 single read" : "R3 two reads", nreads, exp_reads);
      chk(read_log[0] === oa, "R2 outer entry address", {2'b0, read_log[0]}, {2'b0, oa});
      if (exp_reads == 2 && nreads >= 2)
         chk(read_log[1] === ia, "R3 inner entry address", {2'b0, read_log[1]}, {2'b0, ia});
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R9 released after take",
          {30'd0, rsp_valid, req_ready}, 32'd1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] e;
      logic [7:0]  ii;
      repeat (3) @(negedge clk);
      // R1
      chk(req_ready === 1'b1, "R1 req_ready after reset", {31'd0, req_ready}, 32'd1);
      chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
      chk(mem_req_valid === 1'b0, "R1 mem_req_valid after reset", {31'd0, mem_req_valid}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      set_root(30'h0010_0000);
      // R5: outer index 7 lands on an invalid outer entry
      walk(32'h0070_0ABC, 0, 0);
      // R6: pick an inner index that lands on an invalid inner entry
      e  = memf(30'h0010_0000);
      ii = {3'b000, 5'd7 - e[6:2]};
      walk({12'h000, ii, 12'h3C5}, 1, 0);
      // R4 corners of the index and offset fields
      walk(32'h0000_0000, 0, 0);
      walk(32'hFFFF_FFFF, 2, 0);
      walk(32'h0010_1FFF, 0, 0);
      // R8: writes during a walk and together with a request are ignored
      walk(32'h1234_5678, 0, 1);
      walk(32'h2345_6789, 0, 0);
      walk(32'h3456_789A, 0, 2);
      walk(32'h4567_89AB, 0, 0);
      // R2 wraparound of the outer entry address
      set_root(30'h3FFF_FF00);
      walk(32'hFFF0_0123, 0, 0);
      long_lat = 1;
      walk(32'hABC0_1234, 1, 0);
      long_lat = 0;

      for (int i = 0; i < 300; i++) begin
         if (i % 50 == 0) set_root(30'h0010_0000 + 30'(i) * 30'h0001_2340);
         long_lat = (i % 11 == 0);
         walk((32'(i) * 32'h9E37_79B9) ^ (32'(i) << 13), i % 3,
              (i % 17 == 5) ? 1 : ((i % 19 == 7) ? 2 : 0));
      end
      long_lat = 0;

      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule